// File: doc/BRIEF.md
# Fetch-Line Next-Address Predictor

This block steers the instruction fetch address one group at a time. A group is four 32-bit instructions (16 bytes). For every cache line the block keeps a next-address selector, a branch target and a 2-bit saturating history counter. The fetch address register is loaded straight from the selected next address each cycle. Because of this, a correctly predicted taken branch adds no idle fetch cycle.

When a line is filled, the block predecodes the four incoming instructions. It reports four predecode bits per instruction and computes the target of the first branch in the group. That result sets up the line's stored prediction. A resolution port reports how each branch actually went. It moves the history counter up or down. On a mispredict it also loads the corrected address into the fetch register on the following edge, and for a taken outcome it rewrites the line's target.

The instruction cache keeps its own data and tags. This block only supplies the fetch address that the cache should read next.

Top module: `line_predictor`

## Requirements
- R1: After reset, `fetchAddr` equals `RESET_ADDR` (default 0x0000_1000). Every line predicts sequential: `predNext` is the fetch address with bits [3:0] cleared plus 16, and `predTaken` is 0.
- R2: `fillDecode` gives a 4-bit code for each slot of `fillData`, computed combinationally. Slot s is `fillData[32*s+31:32*s]`, with slot 0 at the lowest address. The code for slot s sits at `fillDecode[4*s+3:4*s]`, with these bits:
  - bit 0: the instruction is a branch, meaning opcode bits [31:26] equal 0x30 (conditional) or 0x31 (unconditional);
  - bit 1: the opcode is 0x31;
  - bit 2: the branch has a negative displacement;
  - bit 3: this is the first branch in the group.
- R3: A fill records the first branch of the group. Its target is the group base, plus 4 times its slot, plus the sign-extended 16-bit displacement (bits [15:0]) shifted left by 2. The counter starts at 3 for an unconditional branch and at 1 for a conditional one. A group with no branch predicts sequential.
- R4: With `fetchEn` high and no mispredict, `fetchAddr` takes the value of `predNext` on the next edge. `predNext` is the stored target when the line holds a branch and its counter is 2 or more. Otherwise it is the sequential group address.
- R5: A resolution without a fill to the same line in the same cycle updates that line's counter. A taken outcome adds 1 and stops at 3. A not-taken outcome subtracts 1 and stops at 0.
- R6: A mispredict resolution loads `resTarget` into `fetchAddr` on the next edge, whatever `fetchEn` is. When `resTaken` is also high, the line's target becomes `resTarget` and the line is marked as holding a branch.
- R7: With `fetchEn` low and no mispredict, `fetchAddr` holds its value.
- R8: If a fill and a resolution address the same line in the same cycle, the fill alone sets the line state. The redirect to `resTarget` still takes place.
- R9: The line index is address bits [11:4]. Addresses that differ only above bit 11 share one line, and its absolute target applies to both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fetchEn | input | 1 | Advance fetch to the predicted next address |
| fetchAddr | output | ADDR_W | Current fetch address |
| predNext | output | ADDR_W | Predicted next fetch address for the current line |
| predTaken | output | 1 | Current line predicts a taken branch |
| fillValid | input | 1 | A line fill is presented |
| fillAddr | input | ADDR_W | Address of the filled group |
| fillData | input | 32*SLOTS | Instructions of the filled group, slot 0 lowest |
| fillDecode | output | 4*SLOTS | Predecode bits per slot |
| resValid | input | 1 | A branch resolution is presented |
| resAddr | input | ADDR_W | Fetch address of the line holding the resolved branch |
| resTaken | input | 1 | Resolved outcome was taken |
| resMispredict | input | 1 | The prediction was wrong; redirect fetch |
| resTarget | input | ADDR_W | Corrected next fetch address |

## Verification
The hardest state to set up is a fetch register parked on an arbitrary line while that line's counter is moved through the edges where it saturates. No port reads the counter directly. The bench handles this with a mispredict resolution aimed at a dedicated scratch line: its `resTarget` jumps fetch to any address without touching the line under test. Non-mispredict resolutions then step the counter, and each step shows up on `predNext`. The same jump reaches aliasing addresses, and it reaches the lines that the fill and resolution collision wrote.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef struct packed {
    logic redirect;  // load fetch register from resolution target
    logic advance;   // load fetch register from prediction
    logic fillWr;    // write line state from predecode
    logic resWr;     // update line counter from resolution
    logic tgtWr;     // rewrite line target from resolution
  } lpStrobe_t;
endpackage

// File: rtl/lp_predecode.sv
module lp_predecode #(
  parameter int ADDR_W = 32,
  parameter int SLOTS = 4,
  parameter int DISP_W = 16,
  parameter logic [5:0] OP_COND = 6'h30,
  parameter logic [5:0] OP_JUMP = 6'h31
) (
  input  logic [ADDR_W-1:0]   groupAddr,
  input  logic [32*SLOTS-1:0] fillData,
  output logic [4*SLOTS-1:0]  decode,
  output logic                anyBr,
  output logic                brUncond,
  output logic [ADDR_W-1:0]   brTarget
);
  logic [SLOTS-1:0] isBr, isJmp, isBack;
  logic [SLOTS-1:0][ADDR_W-1:0] slotTgt;
  logic [SLOTS-1:0] firstMask;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [31:0] insn;
    logic [ADDR_W-1:0] dispExt;
    assign insn    = fillData[32*g +: 32];
    assign isJmp[g] = (insn[31:26] == OP_JUMP);
    assign isBr[g]  = (insn[31:26] == OP_COND) || isJmp[g];
    assign isBack[g] = isBr[g] & insn[DISP_W-1];
    assign dispExt = ADDR_W'($signed(insn[DISP_W-1:0]));
    assign slotTgt[g] = groupAddr + ADDR_W'(4 * g) + (dispExt << 2);
  end

  always_comb begin
    anyBr = 1'b0;
    brUncond = 1'b0;
    brTarget = '0;
    firstMask = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (isBr[i] && !anyBr) begin
        anyBr = 1'b1;
        firstMask[i] = 1'b1;
        brTarget = slotTgt[i];
        brUncond = isJmp[i];
      end
    end
    for (int i = 0; i < SLOTS; i++)
      decode[4*i +: 4] = {firstMask[i], isBack[i], isJmp[i], isBr[i]};
  end
endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             fetchEn,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             resValid,
  input  logic             resTaken,
  input  logic             resMispredict,
  input  logic [IDX_W-1:0] resIdx,
  output lpStrobe_t        strb
);
  logic collide;
  assign collide = fillValid && (fillIdx == resIdx);

  always_comb begin
    strb.redirect = resValid & resMispredict;
    strb.advance  = fetchEn & ~strb.redirect;
    strb.fillWr   = fillValid;
    strb.resWr    = resValid & ~collide;
    strb.tgtWr    = resValid & ~collide & resMispredict & resTaken;
  end
endmodule

// File: rtl/lp_data.sv
module lp_data
  import lp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES = 256,
  parameter int OFF_W = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpStrobe_t         strb,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic              fillAnyBr,
  input  logic              fillUncond,
  input  logic [ADDR_W-1:0] fillTarget,
  input  logic [IDX_W-1:0]  resIdx,
  input  logic              resTaken,
  input  logic [ADDR_W-1:0] resTarget,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] predNext,
  output logic              predTaken
);
  logic [1:0]        ctrArr [LINES];
  logic              brArr  [LINES];
  logic [ADDR_W-1:0] tgtArr [LINES];

  logic [IDX_W-1:0]  curIdx;
  logic [ADDR_W-1:0] seqAddr;
  logic [1:0]        resCtr, resCtrNext;

  assign curIdx  = IDX_W'(fetchAddr >> OFF_W);
  assign seqAddr = ((fetchAddr >> OFF_W) + ADDR_W'(1)) << OFF_W;
  assign predTaken = brArr[curIdx] & ctrArr[curIdx][1];
  assign predNext  = predTaken ? tgtArr[curIdx] : seqAddr;

  assign resCtr = ctrArr[resIdx];
  always_comb begin
    if (resTaken) resCtrNext = (resCtr == 2'd3) ? 2'd3 : resCtr + 2'd1;
    else          resCtrNext = (resCtr == 2'd0) ? 2'd0 : resCtr - 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        ctrArr[i] <= 2'd1;
        brArr[i]  <= 1'b0;
      end
    end else begin
      if (strb.resWr) begin
        ctrArr[resIdx] <= resCtrNext;
        if (strb.tgtWr) brArr[resIdx] <= 1'b1;
      end
      if (strb.fillWr) begin
        ctrArr[fillIdx] <= fillUncond ? 2'd3 : 2'd1;
        brArr[fillIdx]  <= fillAnyBr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.tgtWr) tgtArr[resIdx] <= resTarget;
    if (strb.fillWr && fillAnyBr) tgtArr[fillIdx] <= fillTarget;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              fetchAddr <= RESET_ADDR;
    else if (strb.redirect) fetchAddr <= resTarget;
    else if (strb.advance)  fetchAddr <= predNext;
  end

  a_r6_redirect: assert property (@(posedge clk) disable iff (!rstN)
    strb.redirect |=> fetchAddr == $past(resTarget));
  a_r4_follow: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> fetchAddr == $past(predNext));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.redirect && !strb.advance) |=> $stable(fetchAddr));
  a_r5_sat_top: assert property (@(posedge clk) disable iff (!rstN)
    (strb.resWr && resTaken && resCtr == 2'd3) |=> ctrArr[$past(resIdx)] == 2'd3);
  a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (strb.resWr && !resTaken && resCtr == 2'd0) |=> ctrArr[$past(resIdx)] == 2'd0);
  a_r8_fill_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillWr && !fillAnyBr) |=> !brArr[$past(fillIdx)]);
endmodule

// File: rtl/line_predictor.sv
module line_predictor
  import lp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES = 256,
  parameter int SLOTS = 4,
  parameter int DISP_W = 16,
  parameter logic [5:0] OP_COND = 6'h30,
  parameter logic [5:0] OP_JUMP = 6'h31,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fetchEn,
  output logic [ADDR_W-1:0]   fetchAddr,
  output logic [ADDR_W-1:0]   predNext,
  output logic                predTaken,
  input  logic                fillValid,
  input  logic [ADDR_W-1:0]   fillAddr,
  input  logic [32*SLOTS-1:0] fillData,
  output logic [4*SLOTS-1:0]  fillDecode,
  input  logic                resValid,
  input  logic [ADDR_W-1:0]   resAddr,
  input  logic                resTaken,
  input  logic                resMispredict,
  input  logic [ADDR_W-1:0]   resTarget
);
  localparam int OFF_W = $clog2(SLOTS * 4);
  localparam int IDX_W = $clog2(LINES);

  lpStrobe_t strb;
  logic [IDX_W-1:0]  fillIdx, resIdx;
  logic [ADDR_W-1:0] groupAddr, fillTarget;
  logic              fillAnyBr, fillUncond;

  assign fillIdx   = IDX_W'(fillAddr >> OFF_W);
  assign resIdx    = IDX_W'(resAddr >> OFF_W);
  assign groupAddr = (fillAddr >> OFF_W) << OFF_W;

  lp_predecode #(
    .ADDR_W(ADDR_W), .SLOTS(SLOTS), .DISP_W(DISP_W),
    .OP_COND(OP_COND), .OP_JUMP(OP_JUMP)
  ) i_predecode (
    .groupAddr(groupAddr), .fillData(fillData), .decode(fillDecode),
    .anyBr(fillAnyBr), .brUncond(fillUncond), .brTarget(fillTarget)
  );

  lp_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .fetchEn(fetchEn), .fillValid(fillValid), .fillIdx(fillIdx),
    .resValid(resValid), .resTaken(resTaken), .resMispredict(resMispredict),
    .resIdx(resIdx), .strb(strb)
  );

  lp_data #(
    .ADDR_W(ADDR_W), .LINES(LINES), .OFF_W(OFF_W), .RESET_ADDR(RESET_ADDR)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .fillIdx(fillIdx), .fillAnyBr(fillAnyBr), .fillUncond(fillUncond),
    .fillTarget(fillTarget), .resIdx(resIdx), .resTaken(resTaken),
    .resTarget(resTarget), .fetchAddr(fetchAddr), .predNext(predNext),
    .predTaken(predTaken)
  );
endmodule

// File: tb/test_line_predictor.sv
module test_line_predictor;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SCRATCH = 32'h0000_0FF0;

  logic clk = 1'b0, rstN = 1'b0;
  logic fetchEn = 1'b0;
  logic [31:0] fetchAddr, predNext;
  logic predTaken;
  logic fillValid = 1'b0;
  logic [31:0] fillAddr = '0;
  logic [127:0] fillData = '0;
  logic [15:0] fillDecode;
  logic resValid = 1'b0, resTaken = 1'b0, resMispredict = 1'b0;
  logic [31:0] resAddr = '0, resTarget = '0;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_predictor i_line_predictor (
    .clk(clk), .rstN(rstN), .fetchEn(fetchEn), .fetchAddr(fetchAddr),
    .predNext(predNext), .predTaken(predTaken), .fillValid(fillValid),
    .fillAddr(fillAddr), .fillData(fillData), .fillDecode(fillDecode),
    .resValid(resValid), .resAddr(resAddr), .resTaken(resTaken),
    .resMispredict(resMispredict), .resTarget(resTarget)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // jump fetch via mispredict on the scratch line (index 255)
  task automatic goto(logic [31:0] a);
    resValid = 1'b1; resMispredict = 1'b1; resTaken = 1'b0;
    resAddr = SCRATCH; resTarget = a;
    tick();
    resValid = 1'b0; resMispredict = 1'b0;
  endtask

  task automatic resolve(logic [31:0] a, logic tk);
    resValid = 1'b1; resMispredict = 1'b0; resTaken = tk; resAddr = a;
    tick();
    resValid = 1'b0;
  endtask

  function automatic logic [31:0] seqOf(logic [31:0] a);
    return {a[31:4], 4'h0} + 32'd16;
  endfunction

  function automatic logic [31:0] tgtOf(logic [31:0] a, int s, logic [15:0] d);
    logic [31:0] dx;
    dx = {{16{d[15]}}, d};
    return {a[31:4], 4'h0} + 32'(4 * s) + (dx << 2);
  endfunction

  function automatic logic [31:0] insn(logic [5:0] op, logic [15:0] d);
    return {op, 10'h0, d};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++; nTests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] disps [4];
    logic [31:0] la;
    disps[0] = 16'h0005; disps[1] = 16'hFFFE; disps[2] = 16'h7FFF; disps[3] = 16'h8000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset addr", fetchAddr, 32'h0000_1000);
    chk("R1 reset pred", predNext, 32'h0000_1010);
    for (int i = 0; i < 256; i++) begin
      la = 32'h0002_0000 + 32'(i * 16) + 32'h4;
      goto(la);
      chk("R1 line sequential", predNext, seqOf(la));
      chk("R1 not taken", {31'd0, predTaken}, 32'd0);
    end

    // R2/R3 unconditional branch in every slot with edge displacements
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        la = 32'h0003_0100 + 32'((s * 4 + d) * 16);
        fillValid = 1'b1; fillAddr = la + 32'h8;
        for (int k = 0; k < 4; k++)
          fillData[32*k +: 32] = (k == s) ? insn(6'h31, disps[d]) : insn(6'h05, 16'(k + 7));
        #1;
        chk("R2 decode", {16'h0, fillDecode},
            {16'h0, 16'((disps[d][15] ? 16'hF : 16'hB) << (4 * s))});
        tick();
        fillValid = 1'b0;
        goto(la + 32'hC);
        chk("R3 uncond target", predNext, tgtOf(la, s, disps[d]));
      end
    end

    // R9 aliasing: index bits [11:4] only
    goto(32'h0003_1100);
    chk("R9 alias target", predNext, tgtOf(32'h0003_0100, 0, 16'h0005));

    // R2/R3/R5 conditional first branch, later jump ignored
    la = 32'h0004_0280;
    fillValid = 1'b1; fillAddr = la;
    fillData = {insn(6'h31, 16'hFFFF), insn(6'h01, 16'h0), insn(6'h30, 16'h0003), insn(6'h02, 16'h0)};
    #1;
    chk("R2 two branches", {16'h0, fillDecode}, 32'h0000_7090);
    tick();
    fillValid = 1'b0;
    goto(la);
    chk("R3 cond starts not taken", predNext, la + 32'd16);
    resolve(la, 1'b1);
    chk("R5 inc to 2", predNext, tgtOf(la, 1, 16'h0003));
    resolve(la, 1'b1);
    resolve(la, 1'b1);
    chk("R5 at 3", predNext, tgtOf(la, 1, 16'h0003));
    resolve(la, 1'b0);
    chk("R5 saturated top then 2", predNext, tgtOf(la, 1, 16'h0003));
    resolve(la, 1'b0);
    chk("R5 dec to 1", predNext, la + 32'd16);
    for (int k = 0; k < 3; k++) resolve(la, 1'b0);
    resolve(la, 1'b1);
    chk("R5 saturated bottom then 1", predNext, la + 32'd16);
    resolve(la, 1'b1);
    chk("R5 back to 2", predNext, tgtOf(la, 1, 16'h0003));
    chk("R5 predTaken", {31'd0, predTaken}, 32'd1);

    // R3 group without a branch
    fillValid = 1'b1; fillAddr = la;
    fillData = {insn(6'h01, 16'h0), insn(6'h01, 16'h0), insn(6'h01, 16'h0), insn(6'h01, 16'h0)};
    #1;
    chk("R2 no branch", {16'h0, fillDecode}, 32'h0);
    tick();
    fillValid = 1'b0;
    goto(la + 32'h4);
    chk("R3 refill sequential", predNext, la + 32'd16);

    // R4/R6/R7 chained fetch
    fillValid = 1'b1; fillAddr = 32'h0005_0200;
    fillData = {insn(6'h01, 16'h0), insn(6'h31, 16'h0040), insn(6'h01, 16'h0), insn(6'h01, 16'h0)};
    tick();
    fillValid = 1'b0;
    fetchEn = 1'b1;
    goto(32'h0005_0200);
    chk("R6 redirect beats fetchEn", fetchAddr, 32'h0005_0200);
    tick();
    chk("R4 zero-bubble taken", fetchAddr, 32'h0005_0308);
    tick();
    chk("R4 sequential", fetchAddr, 32'h0005_0310);
    tick();
    chk("R4 sequential 2", fetchAddr, 32'h0005_0320);
    fetchEn = 1'b0;
    tick(); tick();
    chk("R7 hold", fetchAddr, 32'h0005_0320);

    // R6 mispredict taken rewrites line
    la = 32'h0006_03C0;
    resValid = 1'b1; resMispredict = 1'b1; resTaken = 1'b1;
    resAddr = la; resTarget = 32'h0007_7774;
    tick();
    resValid = 1'b0; resMispredict = 1'b0;
    chk("R6 fetch corrected", fetchAddr, 32'h0007_7774);
    goto(la);
    chk("R6 line target rewritten", predNext, 32'h0007_7774);

    // R8 fill and resolution collide
    la = 32'h0008_0460;
    fillValid = 1'b1; fillAddr = la;
    fillData = {insn(6'h01, 16'h0), insn(6'h01, 16'h0), insn(6'h01, 16'h0), insn(6'h31, 16'h0002)};
    resValid = 1'b1; resMispredict = 1'b1; resTaken = 1'b1;
    resAddr = la; resTarget = 32'h0009_0000;
    tick();
    fillValid = 1'b0; resValid = 1'b0; resMispredict = 1'b0;
    chk("R8 redirect kept", fetchAddr, 32'h0009_0000);
    goto(la);
    chk("R8 fill target wins", predNext, 32'h0008_0468);
    resolve(la, 1'b0);
    chk("R8 fill counter 3", predNext, 32'h0008_0468);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule